// File: doc/BRIEF.md
# Compare Flags and Branch Resolver

This block gives a small processor pipeline its comparison and branch decisions. A compare operation takes two signed values, a destination and a source. It stores six independent relation flags: greater, greater-or-equal, less, less-or-equal, equal and not-equal. Each flag states how the destination relates to the source. A compare can draw its operands in three ways: an immediate against a register, a register against a register, or a register against an immediate. Fetch, decode and the register file are outside the block. Operand values, the operation select, the branch target and the already-incremented program counter arrive on plain input ports.

A later jump operation either names one of the six flags or is unconditional. The block answers in the same cycle with a taken indication and the next program counter. The next program counter is the branch target when the jump is taken and the incremented program counter when it is not. The flags are also presented on a second output in a fixed display order, for tracing.

Top module: `cmp_branch_unit`

## Requirements
- R1: A synchronous active-high reset clears all six flags to zero.
- R2: After a compare, the flags take the following values, with each relation read as destination against source in signed two's-complement: bit 0 is destination > source, bit 1 is >=, bit 2 is <, bit 3 is <=, bit 4 is equal and bit 5 is not-equal. The flags appear on `flags_o` in the cycle after the compare.
- R3: The operation codes select the compare operands as follows. Code 1 compares destination `dst_reg_i` against source `imm_i`. Code 2 compares destination `dst_reg_i` against source `src_reg_i`. Code 3 compares destination `imm_i` against source `src_reg_i`.
- R4: Each compare replaces all six flags together. No flag value carries over from an earlier compare.
- R5: Any operation that is not a compare leaves the flags unchanged, whatever the operand inputs are. This covers code 0 (no operation) and codes 4 to 10.
- R6: A conditional jump is taken exactly when its one flag is set. Code 5 uses the equal flag, 6 not-equal, 7 less, 8 less-or-equal, 9 greater and 10 greater-or-equal. The decision uses the flags already stored.
- R7: Code 4 is an unconditional jump and is always taken.
- R8: `next_pc_o` equals `target_i` when `taken_o` is high and equals `pc_inc_i` otherwise. `taken_o` is low for every operation that is not a jump.
- R9: `trace_o` shows the flags in display order, from bit 5 down to bit 0: greater-or-equal, greater, less-or-equal, less, not-equal, equal.
- R10: Comparisons are correct at the extremes of the signed range, including the most negative value against the most positive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code_i | input | 4 | Operation select (codes per R3, R5, R6, R7) |
| src_reg_i | input | DATA_W | Source register value |
| dst_reg_i | input | DATA_W | Destination register value |
| imm_i | input | DATA_W | Immediate value |
| target_i | input | PC_W | Jump target |
| pc_inc_i | input | PC_W | Program counter already incremented |
| flags_o | output | 6 | Stored flags, indexed as in R2 |
| trace_o | output | 6 | Flags in display order (R9) |
| taken_o | output | 1 | Jump taken |
| next_pc_o | output | PC_W | Next program counter |

## Verification
The assertions assume that `op_code_i` holds one of the eleven defined codes and that it is sampled at clean clock edges. An undefined code is expected to act as no operation, and the properties make no claim about it. The stimulus only ever drives defined codes. It changes inputs on the falling edge and leaves them steady across each rising edge. The operand sweep covers the signed extremes, small values of both signs and zero, in all three operand forms.

// File: rtl/cmpbr_pkg.sv
package cmpbr_pkg;

    localparam int NREL = 6;
    localparam int REL_GT  = 0;
    localparam int REL_GTE = 1;
    localparam int REL_LT  = 2;
    localparam int REL_LTE = 3;
    localparam int REL_EQ  = 4;
    localparam int REL_NEQ = 5;

    typedef logic [NREL-1:0] rel_t;

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_CMP_IR = 4'd1,
        OP_CMP_RR = 4'd2,
        OP_CMP_RI = 4'd3,
        OP_JMP    = 4'd4,
        OP_JEQ    = 4'd5,
        OP_JNE    = 4'd6,
        OP_JLT    = 4'd7,
        OP_JLE    = 4'd8,
        OP_JGT    = 4'd9,
        OP_JGE    = 4'd10
    } op_e;

    function automatic logic is_compare(op_e op);
        return (op == OP_CMP_IR) || (op == OP_CMP_RR) || (op == OP_CMP_RI);
    endfunction

    // Display position (0 = lowest bit) to stored flag index.
    function automatic int trace_src(int pos);
        case (pos)
            5:       return REL_GTE;
            4:       return REL_GT;
            3:       return REL_LTE;
            2:       return REL_LT;
            1:       return REL_NEQ;
            default: return REL_EQ;
        endcase
    endfunction

endpackage

// File: rtl/operand_mux.sv
module operand_mux
    import cmpbr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  op_e               op_i,
    input  logic [DATA_W-1:0] src_reg_i,
    input  logic [DATA_W-1:0] dst_reg_i,
    input  logic [DATA_W-1:0] imm_i,
    output logic [DATA_W-1:0] lhs_o,
    output logic [DATA_W-1:0] rhs_o,
    output logic              load_o
);
    always_comb begin
        lhs_o  = dst_reg_i;
        rhs_o  = src_reg_i;
        load_o = is_compare(op_i);
        case (op_i)
            OP_CMP_IR: begin lhs_o = dst_reg_i; rhs_o = imm_i;     end
            OP_CMP_RR: begin lhs_o = dst_reg_i; rhs_o = src_reg_i; end
            OP_CMP_RI: begin lhs_o = imm_i;     rhs_o = src_reg_i; end
            default:   ;
        endcase
    end
endmodule

// File: rtl/relation_eval.sv
module relation_eval
    import cmpbr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] lhs_i,
    input  logic [DATA_W-1:0] rhs_i,
    output rel_t              rel_o
);
    logic signed [DATA_W-1:0] a, b;
    logic gt, eq;

    assign a  = $signed(lhs_i);
    assign b  = $signed(rhs_i);
    assign gt = (a > b);
    assign eq = (a == b);

    always_comb begin
        rel_o          = '0;
        rel_o[REL_GT]  = gt;
        rel_o[REL_GTE] = gt | eq;
        rel_o[REL_LT]  = ~(gt | eq);
        rel_o[REL_LTE] = ~gt;
        rel_o[REL_EQ]  = eq;
        rel_o[REL_NEQ] = ~eq;
    end
endmodule

// File: rtl/flag_store.sv
module flag_store
    import cmpbr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  rel_t rel_i,
    output rel_t flags_o
);
    always_ff @(posedge clk) begin
        if (rst)         flags_o <= '0;
        else if (load_i) flags_o <= rel_i;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> flags_o == '0);

    // R5
    hold_flags_chk: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(flags_o));

    // R4
    coherent_flags_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> ($countones({flags_o[REL_EQ], flags_o[REL_NEQ]}) == 1
                    && $countones({flags_o[REL_GT], flags_o[REL_LT], flags_o[REL_EQ]}) == 1
                    && flags_o[REL_GTE] == (flags_o[REL_GT] | flags_o[REL_EQ])
                    && flags_o[REL_LTE] == (flags_o[REL_LT] | flags_o[REL_EQ])));
endmodule

// File: rtl/jump_resolver.sv
module jump_resolver
    import cmpbr_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  op_e             op_i,
    input  rel_t            flags_i,
    input  logic [PC_W-1:0] target_i,
    input  logic [PC_W-1:0] pc_inc_i,
    output logic            taken_o,
    output logic [PC_W-1:0] next_pc_o
);
    always_comb begin
        case (op_i)
            OP_JMP:  taken_o = 1'b1;
            OP_JEQ:  taken_o = flags_i[REL_EQ];
            OP_JNE:  taken_o = flags_i[REL_NEQ];
            OP_JLT:  taken_o = flags_i[REL_LT];
            OP_JLE:  taken_o = flags_i[REL_LTE];
            OP_JGT:  taken_o = flags_i[REL_GT];
            OP_JGE:  taken_o = flags_i[REL_GTE];
            default: taken_o = 1'b0;
        endcase
        next_pc_o = taken_o ? target_i : pc_inc_i;
    end
endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit
    import cmpbr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PC_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_code_i,
    input  logic [DATA_W-1:0] src_reg_i,
    input  logic [DATA_W-1:0] dst_reg_i,
    input  logic [DATA_W-1:0] imm_i,
    input  logic [PC_W-1:0]   target_i,
    input  logic [PC_W-1:0]   pc_inc_i,
    output logic [5:0]        flags_o,
    output logic [5:0]        trace_o,
    output logic              taken_o,
    output logic [PC_W-1:0]   next_pc_o
);
    op_e               op;
    logic [DATA_W-1:0] lhs, rhs;
    logic              load;
    rel_t              rel_now, flags_q;

    assign op = op_e'(op_code_i);

    operand_mux #(.DATA_W(DATA_W)) u_mux (
        .op_i(op), .src_reg_i(src_reg_i), .dst_reg_i(dst_reg_i), .imm_i(imm_i),
        .lhs_o(lhs), .rhs_o(rhs), .load_o(load)
    );

    relation_eval #(.DATA_W(DATA_W)) u_eval (
        .lhs_i(lhs), .rhs_i(rhs), .rel_o(rel_now)
    );

    flag_store u_flags (
        .clk(clk), .rst(rst), .load_i(load), .rel_i(rel_now), .flags_o(flags_q)
    );

    jump_resolver #(.PC_W(PC_W)) u_jump (
        .op_i(op), .flags_i(flags_q), .target_i(target_i), .pc_inc_i(pc_inc_i),
        .taken_o(taken_o), .next_pc_o(next_pc_o)
    );

    assign flags_o = flags_q;

    for (genvar i = 0; i < NREL; i++) begin : g_trace
        localparam int SRC = trace_src(i);
        assign trace_o[i] = flags_q[SRC];
    end

    // R2
    rr_relation_chk: assert property (@(posedge clk) disable iff (rst)
        (op_code_i == OP_CMP_RR) |=>
            flags_o[REL_GT] == ($signed($past(dst_reg_i)) > $signed($past(src_reg_i))));

    // R3
    ri_operand_chk: assert property (@(posedge clk) disable iff (rst)
        (op_code_i == OP_CMP_RI) |=>
            flags_o[REL_LT] == ($signed($past(imm_i)) < $signed($past(src_reg_i))));

    // R3
    ir_operand_chk: assert property (@(posedge clk) disable iff (rst)
        (op_code_i == OP_CMP_IR) |=>
            flags_o[REL_EQ] == ($past(dst_reg_i) == $past(imm_i)));

    // R6
    cond_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (op_code_i == OP_JLE) |-> taken_o == flags_o[REL_LTE]);

    // R7
    always_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (op_code_i == OP_JMP) |-> (taken_o && next_pc_o == target_i));

    // R8
    fallthrough_chk: assert property (@(posedge clk) disable iff (rst)
        !taken_o |-> next_pc_o == pc_inc_i);

    // R8
    nonjump_chk: assert property (@(posedge clk) disable iff (rst)
        (op_code_i < OP_JMP) |-> !taken_o);
endmodule

// File: tb/cmp_branch_unit_tb.sv
module cmp_branch_unit_tb;
    import cmpbr_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_code = 4'd0;
    logic [31:0] src_reg = '0, dst_reg = '0, imm = '0;
    logic [31:0] target = '0, pc_inc = '0;
    logic [5:0]  flags, trace;
    logic        taken;
    logic [31:0] next_pc;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cmp_branch_unit u_dut (
        .clk(clk), .rst(rst), .op_code_i(op_code),
        .src_reg_i(src_reg), .dst_reg_i(dst_reg), .imm_i(imm),
        .target_i(target), .pc_inc_i(pc_inc),
        .flags_o(flags), .trace_o(trace), .taken_o(taken), .next_pc_o(next_pc)
    );

    function automatic logic [5:0] exp_flags(int d, int s);
        logic [5:0] r;
        r[0] = d > s;  r[1] = d >= s; r[2] = d < s;
        r[3] = d <= s; r[4] = d == s; r[5] = d != s;
        return r;
    endfunction

    function automatic logic [5:0] exp_trace(logic [5:0] f);
        return {f[1], f[0], f[3], f[2], f[5], f[4]};
    endfunction

    function automatic int sample_val(int k);
        case (k)
            0: return 32'sh8000_0000;
            1: return -5;
            2: return -1;
            3: return 0;
            4: return 1;
            5: return 5;
            default: return 32'sh7FFF_FFFF;
        endcase
    endfunction

    task automatic check6(string req, logic [5:0] act, logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at falling edge, let a rising edge pass, sample at the next falling edge.
    task automatic run_cycle(logic [3:0] op, int s, int d, int i);
        @(negedge clk);
        op_code = op; src_reg = s; dst_reg = d; imm = i;
        @(negedge clk);
    endtask

    // Combinational jump check with stored flags f.
    task automatic jump_check(logic [3:0] op, logic [5:0] f, int seed);
        logic exp_t;
        @(negedge clk);
        op_code = op; target = 32'h1000 + seed; pc_inc = 32'h2000 + seed;
        src_reg = seed * 7; dst_reg = -seed; imm = seed;
        #2;
        case (op)
            OP_JMP: exp_t = 1'b1;
            OP_JEQ: exp_t = f[4];
            OP_JNE: exp_t = f[5];
            OP_JLT: exp_t = f[2];
            OP_JLE: exp_t = f[3];
            OP_JGT: exp_t = f[0];
            OP_JGE: exp_t = f[1];
            default: exp_t = 1'b0;
        endcase
        check32((op == OP_JMP) ? "R7 taken" : "R6 taken", {31'd0, taken}, {31'd0, exp_t});
        check32("R8 next_pc", next_pc, exp_t ? target : pc_inc);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [5:0] e;
        int n = 0;
        @(negedge clk); @(negedge clk);
        // Load non-zero flags, then reset must clear them
        rst = 1'b0;
        run_cycle(OP_CMP_RR, 1, 9, 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        op_code = OP_NOP;
        @(negedge clk);
        check6("R1 reset flags", flags, 6'd0);
        #2;
        check32("R8 nop not taken", {31'd0, taken}, 32'd0);

        for (int form = 1; form <= 3; form++) begin
            for (int a = 0; a < 7; a++) begin
                for (int b = 0; b < 7; b++) begin
                    int va = sample_val(a);
                    int vb = sample_val(b);
                    // va is destination, vb is source in every form
                    case (form)
                        1: run_cycle(OP_CMP_IR, 32'h55, va, vb);
                        2: run_cycle(OP_CMP_RR, vb, va, 32'h55);
                        default: run_cycle(OP_CMP_RI, vb, 32'h55, va);
                    endcase
                    e = exp_flags(va, vb);
                    check6((a == 0 || a == 6 || b == 0 || b == 6) ? "R10 R3 flags" : "R2 R3 flags", flags, e);
                    check6("R9 trace", trace, exp_trace(e));
                    jump_check(4'(OP_JMP + ((n % 7))), e, n);
                    run_cycle(OP_NOP, -n, n, n + 3);
                    check6("R5 hold", flags, e);
                    n++;
                end
            end
        end

        // R4: a new compare replaces every flag of the previous one
        run_cycle(OP_CMP_RR, -3, 4, 0);
        check6("R4 first", flags, exp_flags(4, -3));
        run_cycle(OP_CMP_RR, 4, 4, 0);
        check6("R4 replaced", flags, exp_flags(4, 4));
        run_cycle(OP_CMP_RI, 9, 0, 2);
        check6("R4 replaced again", flags, exp_flags(2, 9));
        jump_check(OP_JMP, exp_flags(2, 9), 77);

        // R5: each jump opcode leaves the flags alone
        for (int op = 4; op <= 10; op++) begin
            run_cycle(4'(op), 100, -100, 0);
            check6("R5 jump keeps flags", flags, exp_flags(2, 9));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule